// File: doc/BRIEF.md
# Board Control Register Bank

This block is a small memory-mapped register bank for board housekeeping. It sits on a simple 32-bit single-cycle bus and looks only at the low 20 bits of the address, so the whole 1 MiB window folds onto the same register set. It holds three 8-bit output registers: an LED bar, a break/reset byte and a general-purpose output. It also holds an eight-character ASCII display buffer, a soft-reset trigger and a group of bit-banged I2C control registers that drive an external serial EEPROM.

The display buffer can be loaded in two ways. A whole 32-bit word can be written, and the block stores it as eight uppercase hexadecimal characters. Or a single character can be written into one of eight slots, which sit at a stride of 8 bytes. A write of one particular value to the soft-reset register produces a single-cycle system reset request. Any write to the I2C output register sends new SCL/SDA levels to the EEPROM and gives it a one-cycle update strobe. The EEPROM's SDA comes back through the I2C input register.

Top module: `board_ctl_bank`

## Requirements
- R1: After reset: LED bar 0x00, break byte 0x0A, general output 0x00, I2C output-enable 0, I2C output register 0x3 (so SCL=1 and SDA=1), select 1. Every display character is 0x20. disp_chars bits [8i+7:8i] carry character i.
- R2: Only address bits [19:0] are decoded. An address such as 0x1F000408 reaches the same register as 0x408.
- R3: A read of any unmapped offset returns 0, including the write-only display offsets 0x410 to 0x450 and 0x500. A write to an unmapped offset changes no register.
- R4: Offsets 0x200 and 0x210 always read 0. Offset 0x208 reads 0x12 when parameter BIG_END is 1 (the default) and 0x10 when it is 0. Writes to all three have no effect.
- R5: The LED bar (0x408), the break byte (0x508) and the general output (0xA00) are read/write and keep only write data bits [7:0]. Their upper read bits are 0.
- R6: A write to 0x410 fills all eight characters with the uppercase ASCII hex form of the write data. Character 0 gets bits [31:28] and character 7 gets bits [3:0]. Digits map to 0x30-0x39 and A-F map to 0x41-0x46.
- R7: A write to 0x418 + 8*k, for k from 0 to 7, sets character k to write data bits [7:0] and leaves the other characters unchanged.
- R8: A write of exactly 0x00000042 to 0x500 drives sys_rst_req high for exactly one cycle, the cycle after the write. Any other value written there leaves it low.
- R9: I2C output-enable (0xB08) keeps data bits [1:0] and select (0xB18) keeps bit [0]. The I2C output register (0xB10) keeps all 32 bits. i2c_scl follows bit 1 of the output register and i2c_sda follows bit 0.
- R10: Reading 0xB00 returns the stored I2C input value 0x3 with bit 0 replaced by eeprom_sda. It therefore reads 0x2 or 0x3.
- R11: Reading 0xA08 returns the I2C output register when select is 1, and 0 when select is 0.
- R12: Each write to 0xB10 gives a one-cycle i2c_upd pulse in the cycle after the write.
- R13: bus_rdata is registered. It shows the addressed value in the cycle after a bus_rd cycle and holds it while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address; bits [19:0] decoded |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| led_bar | output | 8 | LED bar register |
| brk_reg | output | 8 | Break/reset register |
| gp_out | output | 8 | General-purpose output register |
| disp_chars | output | 64 | Eight ASCII characters, character i in bits [8i+7:8i] |
| sys_rst_req | output | 1 | One-cycle system reset request |
| i2c_oe | output | 2 | I2C output-enable bits |
| i2c_scl | output | 1 | SCL level toward the EEPROM |
| i2c_sda | output | 1 | SDA level toward the EEPROM |
| i2c_upd | output | 1 | One-cycle strobe marking new SCL/SDA levels |
| eeprom_sda | input | 1 | SDA driven back by the EEPROM |

## Verification
Every result of this block is due exactly one clock edge after its bus strobe. On that edge a write updates its register, a display character, sys_rst_req or i2c_upd, and a read loads bus_rdata. The bench drives each strobe for one cycle starting at a falling edge. It samples at the next falling edge, which is when a pulse is visible, and checks again one cycle later so that the pulses are seen to last exactly one cycle and bus_rdata is seen to hold. Checks that a write was ignored read the registers back over the bus or watch the register outputs directly.

// File: rtl/board_ctl_bank.sv
module board_ctl_bank #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int N_CHARS = 8,
  parameter bit BIG_END = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [7:0]           led_bar,
  output logic [7:0]           brk_reg,
  output logic [7:0]           gp_out,
  output logic [8*N_CHARS-1:0] disp_chars,
  output logic                 sys_rst_req,
  output logic [1:0]           i2c_oe,
  output logic                 i2c_scl,
  output logic                 i2c_sda,
  output logic                 i2c_upd,
  input  logic                 eeprom_sda
);
  localparam int          OFF_W     = 20;
  localparam logic [19:0] A_SWITCH  = 20'h00200;
  localparam logic [19:0] A_STATUS  = 20'h00208;
  localparam logic [19:0] A_JUMPER  = 20'h00210;
  localparam logic [19:0] A_LEDS    = 20'h00408;
  localparam logic [19:0] A_HEXWORD = 20'h00410;
  localparam logic [19:0] A_CHAR0   = 20'h00418;
  localparam int          CHAR_STEP = 8;
  localparam logic [19:0] A_SOFTRST = 20'h00500;
  localparam logic [19:0] A_BREAK   = 20'h00508;
  localparam logic [19:0] A_GPOUT   = 20'h00A00;
  localparam logic [19:0] A_GPIN    = 20'h00A08;
  localparam logic [19:0] A_I2CIN   = 20'h00B00;
  localparam logic [19:0] A_I2COE   = 20'h00B08;
  localparam logic [19:0] A_I2COUT  = 20'h00B10;
  localparam logic [19:0] A_I2CSEL  = 20'h00B18;
  localparam logic [DATA_W-1:0] RST_MAGIC   = 'h42;
  localparam logic [DATA_W-1:0] I2C_IN_VAL  = 'h3;
  localparam logic [DATA_W-1:0] I2C_OUT_RST = 'h3;
  localparam logic [DATA_W-1:0] STATUS_VAL  = BIG_END ? 'h12 : 'h10;
  localparam logic [7:0]  BRK_RST   = 8'h0A;
  localparam logic [7:0]  SPACE     = 8'h20;

  logic [OFF_W-1:0]  off;
  logic              unused_hi;
  logic [DATA_W-1:0] i2c_out_q;
  logic              i2c_sel_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_hex;

  assign off       = bus_addr[OFF_W-1:0];
  assign unused_hi = ^bus_addr[ADDR_W-1:OFF_W];
  assign wr_hex    = bus_wr && (off == A_HEXWORD);

  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_bar   <= '0;
      brk_reg   <= BRK_RST;
      gp_out    <= '0;
      i2c_oe    <= '0;
      i2c_out_q <= I2C_OUT_RST;
      i2c_sel_q <= 1'b1;
    end else if (bus_wr) begin
      case (off)
        A_LEDS:   led_bar   <= bus_wdata[7:0];
        A_BREAK:  brk_reg   <= bus_wdata[7:0];
        A_GPOUT:  gp_out    <= bus_wdata[7:0];
        A_I2COE:  i2c_oe    <= bus_wdata[1:0];
        A_I2COUT: i2c_out_q <= bus_wdata;
        A_I2CSEL: i2c_sel_q <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < N_CHARS; i++) begin : g_char
    localparam logic [19:0] A_SLOT = A_CHAR0 + 20'(CHAR_STEP * i);
    logic [7:0] ch_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ch_q <= SPACE;
      else if (wr_hex)
        ch_q <= hex_ascii(bus_wdata[DATA_W-1-4*i -: 4]);
      else if (bus_wr && off == A_SLOT)
        ch_q <= bus_wdata[7:0];
    end
    assign disp_chars[8*i +: 8] = ch_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_rst_req <= 1'b0;
      i2c_upd     <= 1'b0;
    end else begin
      sys_rst_req <= bus_wr && off == A_SOFTRST && bus_wdata == RST_MAGIC;
      i2c_upd     <= bus_wr && off == A_I2COUT;
    end
  end

  assign i2c_scl = i2c_out_q[1];
  assign i2c_sda = i2c_out_q[0];

  always_comb begin
    rd_mux = '0;
    case (off)
      A_SWITCH: rd_mux = '0;
      A_STATUS: rd_mux = STATUS_VAL;
      A_JUMPER: rd_mux = '0;
      A_LEDS:   rd_mux = {{(DATA_W-8){1'b0}}, led_bar};
      A_BREAK:  rd_mux = {{(DATA_W-8){1'b0}}, brk_reg};
      A_GPOUT:  rd_mux = {{(DATA_W-8){1'b0}}, gp_out};
      A_GPIN:   rd_mux = i2c_sel_q ? i2c_out_q : '0;
      A_I2CIN:  rd_mux = {I2C_IN_VAL[DATA_W-1:1], eeprom_sda};
      A_I2COE:  rd_mux = {{(DATA_W-2){1'b0}}, i2c_oe};
      A_I2COUT: rd_mux = i2c_out_q;
      A_I2CSEL: rd_mux = {{(DATA_W-1){1'b0}}, i2c_sel_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux | {{(DATA_W-1){1'b0}}, unused_hi & 1'b0};
  end
endmodule

module board_ctl_bank_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int N_CHARS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [7:0]           led_bar,
  input logic [7:0]           gp_out,
  input logic [8*N_CHARS-1:0] disp_chars,
  input logic                 sys_rst_req,
  input logic                 i2c_upd
);
  logic [19:0] off;
  logic        disp_hit;
  assign off      = bus_addr[19:0];
  assign disp_hit = off >= 20'h410 && off <= 20'h450;

  assert_rst_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(bus_wr && off == 20'h500 && bus_wdata == 'h42));
  assert_upd_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_upd |-> $past(bus_wr && off == 20'hB10));
  assert_led_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led_bar) |-> $past(bus_wr && off == 20'h408));
  assert_gp_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gp_out) |-> $past(bus_wr && off == 20'hA00));
  assert_disp_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_chars) |-> $past(bus_wr && disp_hit));
  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!bus_rd) |-> $stable(bus_rdata));
endmodule

bind board_ctl_bank board_ctl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CHARS(N_CHARS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led_bar(led_bar), .gp_out(gp_out),
  .disp_chars(disp_chars), .sys_rst_req(sys_rst_req), .i2c_upd(i2c_upd)
);

// File: tb/board_ctl_bank_tb_top.sv
module board_ctl_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  led_bar, brk_reg, gp_out;
  logic [63:0] disp_chars;
  logic        sys_rst_req;
  logic [1:0]  i2c_oe;
  logic        i2c_scl, i2c_sda, i2c_upd;
  logic        eeprom_sda = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  board_ctl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led_bar(led_bar), .brk_reg(brk_reg),
    .gp_out(gp_out), .disp_chars(disp_chars), .sys_rst_req(sys_rst_req), .i2c_oe(i2c_oe),
    .i2c_scl(i2c_scl), .i2c_sda(i2c_sda), .i2c_upd(i2c_upd), .eeprom_sda(eeprom_sda)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [7:0] asc(input logic [3:0] n);
    return (n < 10) ? 8'h30 + n : 8'h41 + (n - 10);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 leds", led_bar, 8'h00);
    chk("R1 brk", brk_reg, 8'h0A);
    chk("R1 gp", gp_out, 8'h00);
    chk("R1 oe", i2c_oe, 2'd0);
    chk("R1 scl/sda", {i2c_scl, i2c_sda}, 2'b11);
    chk("R1 disp", disp_chars, {8{8'h20}});
    rd(32'hB18, d); chk("R1 sel", d, 1);
    rd(32'hB10, d); chk("R1 i2c out", d, 3);
  endtask

  task automatic t_consts;
    logic [31:0] d;
    wr(32'h200, 32'hFFFF_FFFF); wr(32'h208, 32'h5); wr(32'h210, 32'h7);
    rd(32'h200, d); chk("R4 switch", d, 0);
    rd(32'h208, d); chk("R4 status", d, 32'h12);
    rd(32'h210, d); chk("R4 jumper", d, 0);
  endtask

  task automatic t_bytes;
    logic [31:0] d;
    wr(32'h408, 32'hDEAD_BEA5); chk("R5 leds port", led_bar, 8'hA5);
    rd(32'h408, d); chk("R5 leds read", d, 32'hA5);
    wr(32'h508, 32'h1234_5677); rd(32'h508, d); chk("R5 brk read", d, 32'h77);
    wr(32'hA00, 32'hFFFF_FF3C); rd(32'hA00, d); chk("R5 gp read", d, 32'h3C);
    wr(32'h1F000408, 32'h0000_0011); chk("R2 alias write", led_bar, 8'h11);
    rd(32'hFFF00508, d); chk("R2 alias read", d, 32'h77);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(32'h404, 32'hFFFF_FFFF); wr(32'h00B04, 32'hFFFF_FFFF);
    chk("R3 leds untouched", led_bar, 8'h11);
    chk("R3 gp untouched", gp_out, 8'h3C);
    chk("R3 brk untouched", brk_reg, 8'h77);
    chk("R3 disp untouched", disp_chars, {8{8'h20}});
    rd(32'h404, d); chk("R3 unmapped read", d, 0);
    rd(32'h410, d); chk("R3 hexword read", d, 0);
  endtask

  task automatic t_hex(input logic [31:0] v);
    logic [63:0] e;
    for (int i = 0; i < 8; i++) e[8*i +: 8] = asc(v[31-4*i -: 4]);
    wr(32'h410, v); chk("R6 hex word", disp_chars, e);
  endtask

  task automatic t_chars;
    logic [63:0] e;
    e = disp_chars;
    for (int k = 0; k < 8; k++) begin
      wr(32'h418 + 8*k, 32'hFFFF_FF00 | (8'h61 + k));
      e[8*k +: 8] = 8'h61 + k;
      chk("R7 char slot", disp_chars, e);
    end
    wr(32'h41C, 32'h5A); chk("R3 off-stride char", disp_chars, e);
  endtask

  task automatic t_softrst;
    wr(32'h500, 32'h43); chk("R8 wrong value", sys_rst_req, 0);
    wr(32'h500, 32'h142); chk("R8 high bits", sys_rst_req, 0);
    wr(32'h508, 32'h42); chk("R8 wrong offset", sys_rst_req, 0);
    wr(32'h500, 32'h42); chk("R8 pulse", sys_rst_req, 1);
    @(negedge clk); chk("R8 one cycle", sys_rst_req, 0);
  endtask

  task automatic t_i2c;
    logic [31:0] d;
    wr(32'hB08, 32'hFFFF_FFFE); chk("R9 oe", i2c_oe, 2'b10);
    wr(32'hB10, 32'hCAFE_0002);
    chk("R12 upd", i2c_upd, 1); chk("R9 scl/sda", {i2c_scl, i2c_sda}, 2'b10);
    @(negedge clk); chk("R12 one cycle", i2c_upd, 0);
    rd(32'hB10, d); chk("R9 full out", d, 32'hCAFE_0002);
    rd(32'hA08, d); chk("R11 sel=1", d, 32'hCAFE_0002);
    wr(32'hB18, 32'hFFFF_FFFE); rd(32'hB18, d); chk("R9 sel bit", d, 0);
    rd(32'hA08, d); chk("R11 sel=0", d, 0);
    wr(32'hB10, 32'h1); chk("R9 sda", {i2c_scl, i2c_sda}, 2'b01);
    eeprom_sda = 1'b0; rd(32'hB00, d); chk("R10 sda low", d, 2);
    eeprom_sda = 1'b1; rd(32'hB00, d); chk("R10 sda high", d, 3);
  endtask

  task automatic t_rdata;
    logic [31:0] d;
    rd(32'h408, d);
    @(negedge clk); bus_addr = 32'h508;
    @(negedge clk); chk("R13 hold", bus_rdata, 32'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_consts; t_bytes; t_unmapped;
    t_hex(32'h0123_4567); t_hex(32'h89AB_CDEF); t_hex(32'hF0A9_5C3B);
    t_chars; t_softrst; t_i2c; t_rdata;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule